// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block computes and records the architectural side effects of taking a trap in a processor with register windows and three privilege levels: user, privileged and hyperprivileged. The pipeline presents the current values of the trap level, global level, condition codes, address space identifier, processor state, hypervisor state, window pointer, window save count and the two program counters. It also presents the trap type, a flag that sends the trap to the hypervisor and a flag that forces the reset/error (RED) entry path. On the cycle that the take strobe is high, the unit registers the post-trap control state. In the same edge it writes one trap-stack level with the pre-trap context.

The trap stack holds one entry per level. Each entry contains a packed state word, the saved PC and NPC, the saved hypervisor state and the trap type. Any level can be read back through a level-indexed read port. Vector generation, choosing between competing traps, and the return path are handled elsewhere.

Processor-state bit positions used by the block: ie=1, priv=2, am=3, pef=4, tle=8, cle=9. Hypervisor-state bit positions: tlz=0, hpriv=2, red=5, ibe=10.

Top module: `trap_entry_unit`

## Requirements
- R1: A strobe accepted with cur_tl < MAX_TL sets new_tl to cur_tl+1 after that clock edge, writes the stack level cur_tl+1, and a read of that level through rd_lvl returns the written entry.
- R2: The saved state word carries GL in bits 42:40, CCR in 39:32, ASI in 31:24, the processor state in 20:8 and the window pointer (zero-extended) in 4:0. All other bits are zero.
- R3: The saved PC and NPC keep only their low 32 bits when cur_pstate bit 3 (am) is 1, and all 64 bits otherwise.
- R4: new_gl is min(cur_gl+1, MAX_PGL) for a privileged destination and min(cur_gl+1, MAX_GL) for a hypervisor or RED destination.
- R5: For a privileged destination (both flags low), new_pstate equals cur_pstate with pef=1, am=0, ie=0, priv=1 and cle set to the value of tle. new_hpstate equals cur_hpstate.
- R6: For a hypervisor destination (to_hyp high, to_red low), new_pstate equals cur_pstate with pef=1, am=0, ie=0 and cle=0. new_hpstate equals cur_hpstate with red=0, hpriv=1 and ibe=0.
- R7: When to_red is high, whatever the value of to_hyp, new_pstate is all zero except that priv keeps its old value and pef=1. new_hpstate equals cur_hpstate with red=1, hpriv=1, ibe=0 and tlz=0.
- R8: new_cwp is cur_cwp+1 for trap type 0x24, cur_cwp+cur_cansave+2 for types 0x80 to 0xBF, and cur_cwp-1 for types 0xC0 to 0xFF, all modulo NWIN. For every other type it equals cur_cwp.
- R9: The stack entry stores the pre-trap hypervisor state and the trap type exactly as presented on the strobe cycle.
- R10: After reset all outputs read zero and every stack level reads zero. With the strobe low, or with cur_tl equal to MAX_TL, the outputs and the stack keep their values.
- R11: Every update becomes visible at the outputs and the read port on the clock edge that samples the strobe, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take | input | 1 | Trap-take strobe |
| to_hyp | input | 1 | Trap goes to hypervisor level |
| to_red | input | 1 | Trap enters RED state |
| ttype | input | 9 | Trap type |
| cur_tl | input | TLW | Current trap level |
| cur_gl | input | GLW | Current global level |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_pstate | input | 13 | Processor state |
| cur_hpstate | input | 12 | Hypervisor state |
| cur_cwp | input | CWPW | Current window pointer |
| cur_cansave | input | CWPW | Windows available to save |
| cur_pc | input | PC_W | Program counter |
| cur_npc | input | PC_W | Next program counter |
| new_tl | output | TLW | Trap level after trap |
| new_gl | output | GLW | Global level after trap |
| new_pstate | output | 13 | Processor state after trap |
| new_hpstate | output | 12 | Hypervisor state after trap |
| new_cwp | output | CWPW | Window pointer after trap |
| rd_lvl | input | TLW | Stack level to read |
| rd_tstate | output | 43 | Saved packed state word |
| rd_tpc | output | PC_W | Saved PC |
| rd_tnpc | output | PC_W | Saved NPC |
| rd_htstate | output | 12 | Saved hypervisor state |
| rd_tt | output | 9 | Saved trap type |

## Verification
A corrupted stack write appears on the read port in the cycle after the strobe, at the level just above the old trap level. If the unit writes the wrong level, the expected level keeps its stale contents. A wrong window, global-level or state decision shows on the new_* outputs one edge after the strobe. The sweep crosses every destination mode with every window pointer and save count and with types on each range edge, so an off-by-one at a range boundary or a missing modulo wrap shows up at once. It also drives a strobe at the top level, which would expose an overflow write.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int NWIN    = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 6,
  parameter int MAX_PGL = 2,
  parameter int PC_W    = 64,
  localparam int TLW  = $clog2(MAX_TL + 2),
  localparam int GLW  = $clog2(MAX_GL + 1),
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            to_hyp,
  input  logic            to_red,
  input  logic [8:0]      ttype,
  input  logic [TLW-1:0]  cur_tl,
  input  logic [GLW-1:0]  cur_gl,
  input  logic [7:0]      cur_ccr,
  input  logic [7:0]      cur_asi,
  input  logic [12:0]     cur_pstate,
  input  logic [11:0]     cur_hpstate,
  input  logic [CWPW-1:0] cur_cwp,
  input  logic [CWPW-1:0] cur_cansave,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] cur_npc,
  output logic [TLW-1:0]  new_tl,
  output logic [GLW-1:0]  new_gl,
  output logic [12:0]     new_pstate,
  output logic [11:0]     new_hpstate,
  output logic [CWPW-1:0] new_cwp,
  input  logic [TLW-1:0]  rd_lvl,
  output logic [42:0]     rd_tstate,
  output logic [PC_W-1:0] rd_tpc,
  output logic [PC_W-1:0] rd_tnpc,
  output logic [11:0]     rd_htstate,
  output logic [8:0]      rd_tt
);
  localparam int DEPTH = MAX_TL + 1;
  localparam int P_IE = 1, P_PRIV = 2, P_AM = 3, P_PEF = 4, P_TLE = 8, P_CLE = 9;
  localparam int H_TLZ = 0, H_HPRIV = 2, H_RED = 5, H_IBE = 10;

  logic [42:0]     stk_ts  [DEPTH];
  logic [PC_W-1:0] stk_pc  [DEPTH];
  logic [PC_W-1:0] stk_npc [DEPTH];
  logic [11:0]     stk_hs  [DEPTH];
  logic [8:0]      stk_tt  [DEPTH];

  logic            accept;
  logic [TLW-1:0]  lvl;
  logic [GLW-1:0]  gl_nx;
  logic [CWPW-1:0] cwp_nx;
  logic [12:0]     ps_nx;
  logic [11:0]     hs_nx;
  logic [PC_W-1:0] pc_mask;
  logic [42:0]     packed_ts;

  assign accept    = take && (int'(cur_tl) < MAX_TL);
  assign lvl       = cur_tl + 1'b1;
  assign pc_mask   = cur_pstate[P_AM] ? PC_W'(64'hFFFF_FFFF) : '1;
  assign packed_ts = {cur_gl, cur_ccr, cur_asi, 3'b000, cur_pstate, 3'b000, 5'(cur_cwp)};

  always_comb begin
    int cap;
    int inc;
    cap   = (to_red || to_hyp) ? MAX_GL : MAX_PGL;
    inc   = int'(cur_gl) + 1;
    gl_nx = GLW'((inc > cap) ? cap : inc);
  end

  always_comb begin
    if (ttype == 9'h024)
      cwp_nx = CWPW'((int'(cur_cwp) + 1) % NWIN);
    else if (ttype >= 9'h080 && ttype <= 9'h0BF)
      cwp_nx = CWPW'((int'(cur_cwp) + int'(cur_cansave) + 2) % NWIN);
    else if (ttype >= 9'h0C0 && ttype <= 9'h0FF)
      cwp_nx = CWPW'((int'(cur_cwp) + NWIN - 1) % NWIN);
    else
      cwp_nx = cur_cwp;
  end

  always_comb begin
    ps_nx = cur_pstate;
    hs_nx = cur_hpstate;
    if (to_red) begin
      ps_nx         = '0;
      ps_nx[P_PRIV] = cur_pstate[P_PRIV];
      ps_nx[P_PEF]  = 1'b1;
      hs_nx[H_RED]  = 1'b1;
      hs_nx[H_HPRIV]= 1'b1;
      hs_nx[H_IBE]  = 1'b0;
      hs_nx[H_TLZ]  = 1'b0;
    end else begin
      ps_nx[P_PEF] = 1'b1;
      ps_nx[P_AM]  = 1'b0;
      ps_nx[P_IE]  = 1'b0;
      if (to_hyp) begin
        ps_nx[P_CLE]   = 1'b0;
        hs_nx[H_RED]   = 1'b0;
        hs_nx[H_HPRIV] = 1'b1;
        hs_nx[H_IBE]   = 1'b0;
      end else begin
        ps_nx[P_PRIV] = 1'b1;
        ps_nx[P_CLE]  = cur_pstate[P_TLE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_tl      <= '0;
      new_gl      <= '0;
      new_pstate  <= '0;
      new_hpstate <= '0;
      new_cwp     <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_ts[i]  <= '0;
        stk_pc[i]  <= '0;
        stk_npc[i] <= '0;
        stk_hs[i]  <= '0;
        stk_tt[i]  <= '0;
      end
    end else if (accept) begin
      new_tl      <= lvl;
      new_gl      <= gl_nx;
      new_pstate  <= ps_nx;
      new_hpstate <= hs_nx;
      new_cwp     <= cwp_nx;
      stk_ts[lvl]  <= packed_ts;
      stk_pc[lvl]  <= cur_pc & pc_mask;
      stk_npc[lvl] <= cur_npc & pc_mask;
      stk_hs[lvl]  <= cur_hpstate;
      stk_tt[lvl]  <= ttype;
    end
  end

  logic rd_ok;
  assign rd_ok      = int'(rd_lvl) < DEPTH;
  assign rd_tstate  = rd_ok ? stk_ts[rd_lvl]  : '0;
  assign rd_tpc     = rd_ok ? stk_pc[rd_lvl]  : '0;
  assign rd_tnpc    = rd_ok ? stk_npc[rd_lvl] : '0;
  assign rd_htstate = rd_ok ? stk_hs[rd_lvl]  : '0;
  assign rd_tt      = rd_ok ? stk_tt[rd_lvl]  : '0;

  a_r1_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> new_tl == $past(cur_tl) + 1'b1);
  a_r4_gl_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !to_red && !to_hyp) |=> int'(new_gl) <= MAX_PGL);
  a_r7_red_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && to_red) |=> new_hpstate[H_RED] && new_hpstate[H_HPRIV] && !new_pstate[P_IE]);
  a_r8_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ttype != 9'h024 && (ttype < 9'h080 || ttype > 9'h0FF)) |=> new_cwp == $past(cur_cwp));
  a_r9_type_saved: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> stk_tt[$past(lvl)] == $past(ttype) && stk_hs[$past(lvl)] == $past(cur_hpstate));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && $past(rst_n)) |=> $stable(new_tl) && $stable(new_gl) && $stable(new_cwp));
  a_r8_window_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(new_cwp) < NWIN);
endmodule

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
  localparam int NWIN = 8, MAX_TL = 6, MAX_GL = 6, MAX_PGL = 2, PC_W = 64;
  localparam int TLW = $clog2(MAX_TL + 2), GLW = $clog2(MAX_GL + 1), CWPW = $clog2(NWIN);

  logic clk = 0, rst_n = 0, take = 0, to_hyp = 0, to_red = 0;
  logic [8:0] ttype = '0;
  logic [TLW-1:0] cur_tl = '0, rd_lvl = '0;
  logic [GLW-1:0] cur_gl = '0;
  logic [7:0] cur_ccr = '0, cur_asi = '0;
  logic [12:0] cur_pstate = '0;
  logic [11:0] cur_hpstate = '0;
  logic [CWPW-1:0] cur_cwp = '0, cur_cansave = '0;
  logic [PC_W-1:0] cur_pc = '0, cur_npc = '0;
  logic [TLW-1:0] new_tl;
  logic [GLW-1:0] new_gl;
  logic [12:0] new_pstate;
  logic [11:0] new_hpstate, rd_htstate;
  logic [CWPW-1:0] new_cwp;
  logic [42:0] rd_tstate;
  logic [PC_W-1:0] rd_tpc, rd_tnpc;
  logic [8:0] rd_tt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_entry_unit #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL), .PC_W(PC_W)) i_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .take(take), .to_hyp(to_hyp), .to_red(to_red), .ttype(ttype),
    .cur_tl(cur_tl), .cur_gl(cur_gl), .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate),
    .cur_hpstate(cur_hpstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_pc(cur_pc),
    .cur_npc(cur_npc), .new_tl(new_tl), .new_gl(new_gl), .new_pstate(new_pstate),
    .new_hpstate(new_hpstate), .new_cwp(new_cwp), .rd_lvl(rd_lvl), .rd_tstate(rd_tstate),
    .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_htstate(rd_htstate), .rd_tt(rd_tt));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [8:0] tts [9] = '{9'h024, 9'h080, 9'h0A5, 9'h0BF, 9'h0C0, 9'h0FF, 9'h100, 9'h010, 9'h07F};

  initial begin
    int k;
    int e_gl, e_cwp, cap;
    logic [12:0] e_ps;
    logic [11:0] e_hs;
    logic [63:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset tl", 64'(new_tl), 0);
    chk("R10 reset pstate", 64'(new_pstate), 0);
    rd_lvl = 1;
    #0.1;
    chk("R10 reset stack", 64'(rd_tpc), 0);
    k = 0;
    for (int mode = 0; mode < 3; mode++)
      for (int g = 0; g < 8; g++)
        for (int ti = 0; ti < 9; ti++)
          for (int c = 0; c < NWIN; c++)
            for (int s = 0; s < NWIN; s++) begin
              k++;
              to_red = (mode == 2);
              to_hyp = (mode == 1) || (mode == 2 && g[0]);
              ttype = tts[ti];
              cur_tl = TLW'(k % MAX_TL);
              cur_gl = GLW'(g);
              cur_ccr = 8'(k * 37);
              cur_asi = 8'(k * 11 + 5);
              cur_pstate = 13'(k * 419 + g * 7);
              cur_hpstate = 12'(k * 293 + s);
              cur_cwp = CWPW'(c);
              cur_cansave = CWPW'(s);
              cur_pc = {32'hC0DE_0000 ^ 32'(k), 32'h1000_0000 + 32'(k * 4)};
              cur_npc = cur_pc + 4;
              rd_lvl = cur_tl + 1'b1;
              take = 1;
              @(negedge clk);
              take = 0;
              cap = (mode == 0) ? MAX_PGL : MAX_GL;
              e_gl = (g + 1 > cap) ? cap : g + 1;
              if (ttype == 9'h024) e_cwp = (c + 1) % NWIN;
              else if (ttype >= 9'h080 && ttype <= 9'h0BF) e_cwp = (c + s + 2) % NWIN;
              else if (ttype >= 9'h0C0 && ttype <= 9'h0FF) e_cwp = (c + NWIN - 1) % NWIN;
              else e_cwp = c;
              e_ps = cur_pstate; e_hs = cur_hpstate;
              if (mode == 2) begin
                e_ps = 13'h0010 | (cur_pstate & 13'h0004);
                e_hs = (cur_hpstate & ~12'h401 & ~12'h001) | 12'h024;
              end else begin
                e_ps = (cur_pstate & ~13'h000A) | 13'h0010;
                if (mode == 1) begin
                  e_ps = e_ps & ~13'h0200;
                  e_hs = (cur_hpstate & ~12'h420) | 12'h004;
                end else begin
                  e_ps = (e_ps | 13'h0004) & ~13'h0200;
                  e_ps = e_ps | (13'(cur_pstate[8]) << 9);
                end
              end
              m = cur_pstate[3] ? 64'hFFFF_FFFF : '1;
              chk("R1 R11 new_tl", 64'(new_tl), 64'(cur_tl) + 1);
              chk("R4 new_gl", 64'(new_gl), 64'(e_gl));
              chk(mode == 2 ? "R7 pstate" : (mode == 1 ? "R6 pstate" : "R5 pstate"), 64'(new_pstate), 64'(e_ps));
              chk(mode == 2 ? "R7 hpstate" : (mode == 1 ? "R6 hpstate" : "R5 hpstate"), 64'(new_hpstate), 64'(e_hs));
              chk("R8 new_cwp", 64'(new_cwp), 64'(e_cwp));
              chk("R2 tstate", 64'(rd_tstate),
                  64'({cur_gl, cur_ccr, cur_asi, 3'b0, cur_pstate, 3'b0, 5'(cur_cwp)}));
              chk("R3 tpc", rd_tpc, cur_pc & m);
              chk("R3 tnpc", rd_tnpc, cur_npc & m);
              chk("R9 htstate", 64'(rd_htstate), 64'(cur_hpstate));
              chk("R9 tt", 64'(rd_tt), 64'(ttype));
            end
    // R10: strobe at top level and strobe low are both ignored
    begin
      logic [TLW-1:0] h_tl; logic [12:0] h_ps; logic [CWPW-1:0] h_cwp; logic [GLW-1:0] h_gl;
      h_tl = new_tl; h_ps = new_pstate; h_cwp = new_cwp; h_gl = new_gl;
      rd_lvl = 1;
      #0.1;
      m = rd_tpc;
      cur_tl = TLW'(MAX_TL); ttype = 9'h024; cur_gl = 0; cur_pstate = 13'h1FFF; to_red = 0; to_hyp = 0;
      cur_cwp = CWPW'(h_cwp + 3'd3);
      take = 1;
      @(negedge clk);
      take = 0;
      chk("R10 top tl", 64'(new_tl), 64'(h_tl));
      chk("R10 top pstate", 64'(new_pstate), 64'(h_ps));
      chk("R10 top cwp", 64'(new_cwp), 64'(h_cwp));
      cur_tl = 0; cur_pc = 64'hDEAD;
      @(negedge clk);
      chk("R10 idle gl", 64'(new_gl), 64'(h_gl));
      chk("R10 idle stack", rd_tpc, m);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule